// File: doc/BRIEF.md
# T1 Carrier Loss and All-Ones Alarm Detector

This block watches the recovered dual-rail receive data of a T1 line and raises two alarm levels. Each line clock edge is one bit time. A bit time is a "space" when neither the positive nor the negative rail carries a pulse, and a "mark" when either rail does. A long unbroken run of spaces means the carrier is gone. A pair of frames that is almost all marks means the far end is sending the all-ones alarm indication signal (AIS), also called blue alarm.

The framer supplies a one-cycle strobe during each framing bit. The block treats that strobe as the frame boundary, and it never counts the framing bit itself. The block also drives a loss-of-sync level for the auto-resync scheme. That level rises on an out-of-frame report or on carrier loss, and it holds while the framer reports that a resync search is in progress.

Top module: `t1_alarm_detect`

## Requirements
- R1: `carrier_loss` rises right after the edge that samples the 32nd consecutive space bit time. It is still low after 31 such bit times.
- R2: After any mark, `carrier_loss` is low. The space-run count then starts again from zero.
- R3: The space-run count saturates at 32 and never wraps, so `carrier_loss` stays high through any longer run of spaces.
- R4: A pulse on only one rail, positive or negative, counts as a mark and breaks the run.
- R5: The AIS level changes only at an edge where `frame_bit` is high. There it is set when the data bits of the frame just completed and the frame before it hold fewer than 3 spaces in total.
- R6: A space in a framing bit position (an edge with `frame_bit` high) never adds to the AIS space count.
- R7: The AIS level clears at a boundary where the two-frame window holds 3 or more spaces.
- R8: After reset, the AIS level is not evaluated until two complete frames, each bounded by framing strobes, have been seen.
- R9: With `resync_auto_en` high, `loss_of_sync` is high one cycle after `oof_event` is sampled high. It is also high one cycle after `carrier_loss` is high.
- R10: `loss_of_sync` stays high while `resync_busy` is high. It falls one cycle after the last cause goes away.
- R11: With `resync_auto_en` low, `loss_of_sync` is low one cycle later.
- R12: During and right after reset, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock, one bit per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pos | input | 1 | Positive-rail pulse for this bit time |
| rx_neg | input | 1 | Negative-rail pulse for this bit time |
| frame_bit | input | 1 | High during the framing bit, one cycle per frame |
| resync_auto_en | input | 1 | Enables the auto-resync loss-of-sync output |
| oof_event | input | 1 | Out-of-frame report from the framer |
| resync_busy | input | 1 | Framer is searching for alignment |
| carrier_loss | output | 1 | Long run of spaces detected |
| ais_alarm | output | 1 | All-ones (blue) alarm level |
| loss_of_sync | output | 1 | Resync in progress indication |

## Verification
The assertions rely on three properties of the framer's inputs. `frame_bit` is a single-cycle pulse that comes once per frame. `oof_event` and `resync_busy` are only meaningful while auto-resync is enabled, but they may arrive at any time. The AIS stability property also requires that no framing strobe arrives between frame boundaries. The stimulus keeps to these rules: it sends exactly one strobe after every 192 data bits, and it raises the out-of-frame and busy inputs only between whole bit times. Space runs in the AIS frames are kept to at most three bits, so carrier loss and AIS never overlap.

// File: rtl/t1_alarm_pkg.sv
package t1_alarm_pkg;

    typedef struct packed {
        logic carrier_loss;
        logic ais;
        logic los;
    } t1_alarm_t;

    // A bit time with no pulse on either rail.
    function automatic logic line_space(input logic pos, input logic neg);
        return !(pos || neg);
    endfunction

endpackage

// File: rtl/t1_zero_run.sv
module t1_zero_run #(
    parameter int RUN_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic space,
    output logic loss
);
    localparam int W = $clog2(RUN_LEN + 1);
    localparam logic [W-1:0] RUN_L = RUN_LEN[W-1:0];

    typedef struct packed {
        logic [W-1:0] cnt;
    } run_st_t;

    run_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!space) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != RUN_L) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign loss = (st_q.cnt == RUN_L);
endmodule

// File: rtl/t1_ais_window.sv
module t1_ais_window #(
    parameter int MIN_SPACES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic space,
    input  logic frame_bit,
    output logic ais
);
    localparam int W = $clog2(MIN_SPACES + 1);
    localparam logic [W-1:0] SAT_L = MIN_SPACES[W-1:0];
    localparam logic [W:0]   MIN_L = MIN_SPACES[W:0];

    typedef struct packed {
        logic [W-1:0] cur;
        logic [W-1:0] prev;
        logic         started;
        logic         have_prev;
        logic         ais;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [W:0] total;

    always_comb begin
        st_d  = st_q;
        total = {1'b0, st_q.cur} + {1'b0, st_q.prev};
        if (frame_bit) begin
            if (st_q.started && st_q.have_prev) begin
                st_d.ais = (total < MIN_L);
            end
            if (st_q.started) begin
                st_d.have_prev = 1'b1;
            end
            st_d.prev    = st_q.cur;
            st_d.started = 1'b1;
            st_d.cur     = '0;
        end else if (space && st_q.cur != SAT_L) begin
            st_d.cur = st_q.cur + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ais = st_q.ais;
endmodule

// File: rtl/t1_los_track.sv
module t1_los_track (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic oof_event,
    input  logic carrier_loss,
    input  logic busy,
    output logic los
);
    typedef struct packed {
        logic los;
    } los_st_t;

    los_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.los = auto_en && (oof_event || carrier_loss || (st_q.los && busy));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign los = st_q.los;
endmodule

// File: rtl/t1_alarm_detect.sv
module t1_alarm_detect #(
    parameter int RUN_LEN    = 32,
    parameter int MIN_SPACES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pos,
    input  logic rx_neg,
    input  logic frame_bit,
    input  logic resync_auto_en,
    input  logic oof_event,
    input  logic resync_busy,
    output logic carrier_loss,
    output logic ais_alarm,
    output logic loss_of_sync
);
    import t1_alarm_pkg::*;

    logic      space;
    t1_alarm_t alm;

    assign space = line_space(rx_pos, rx_neg);

    t1_zero_run #(.RUN_LEN(RUN_LEN)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .space (space),
        .loss  (alm.carrier_loss)
    );

    t1_ais_window #(.MIN_SPACES(MIN_SPACES)) u_ais (
        .clk       (clk),
        .rst_n     (rst_n),
        .space     (space),
        .frame_bit (frame_bit),
        .ais       (alm.ais)
    );

    t1_los_track u_los (
        .clk          (clk),
        .rst_n        (rst_n),
        .auto_en      (resync_auto_en),
        .oof_event    (oof_event),
        .carrier_loss (alm.carrier_loss),
        .busy         (resync_busy),
        .los          (alm.los)
    );

    assign carrier_loss = alm.carrier_loss;
    assign ais_alarm    = alm.ais;
    assign loss_of_sync = alm.los;
endmodule

// File: rtl/t1_alarm_detect_chk.sv
module t1_alarm_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_pos,
    input logic rx_neg,
    input logic frame_bit,
    input logic resync_auto_en,
    input logic oof_event,
    input logic carrier_loss,
    input logic ais_alarm,
    input logic loss_of_sync
);
    assert_rise_on_space_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier_loss) |-> $past(!rx_pos && !rx_neg));

    assert_mark_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pos || rx_neg) |=> !carrier_loss);

    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_loss && !rx_pos && !rx_neg) |=> carrier_loss);

    assert_ais_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_bit |=> $stable(ais_alarm));

    assert_los_on_oof_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resync_auto_en && oof_event) |=> loss_of_sync);

    assert_los_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !resync_auto_en |=> !loss_of_sync);
endmodule

bind t1_alarm_detect t1_alarm_detect_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_pos         (rx_pos),
    .rx_neg         (rx_neg),
    .frame_bit      (frame_bit),
    .resync_auto_en (resync_auto_en),
    .oof_event      (oof_event),
    .carrier_loss   (carrier_loss),
    .ais_alarm      (ais_alarm),
    .loss_of_sync   (loss_of_sync)
);

// File: tb/t1_alarm_detect_tb.sv
`timescale 1ns/1ps
module t1_alarm_detect_tb;
    localparam int DATA_BITS = 192;
    localparam int NVEC = 9;
    // frame A spaces, frame B spaces, framing bits sent as spaces, expected AIS
    localparam int VA [NVEC] = '{0, 1, 2, 1, 3, 0, 0, 2, 0};
    localparam int VB [NVEC] = '{0, 1, 0, 2, 0, 0, 2, 1, 1};
    localparam int VF [NVEC] = '{0, 0, 0, 0, 0, 1, 1, 0, 0};
    localparam int VE [NVEC] = '{1, 1, 1, 0, 0, 1, 1, 0, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_pos = 1'b0, rx_neg = 1'b0, frame_bit = 1'b0;
    logic resync_auto_en = 1'b0, oof_event = 1'b0, resync_busy = 1'b0;
    logic carrier_loss, ais_alarm, loss_of_sync;
    logic tog = 1'b0;
    int   n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    t1_alarm_detect u_dut (
        .clk(clk), .rst_n(rst_n), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .frame_bit(frame_bit), .resync_auto_en(resync_auto_en),
        .oof_event(oof_event), .resync_busy(resync_busy),
        .carrier_loss(carrier_loss), .ais_alarm(ais_alarm),
        .loss_of_sync(loss_of_sync)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bit_time(input logic p, input logic n, input logic f);
        @(negedge clk);
        rx_pos = p; rx_neg = n; frame_bit = f;
        @(posedge clk);
        #1;
    endtask

    task automatic mark(input logic f);
        tog = ~tog;
        bit_time(tog, ~tog, f);
    endtask

    task automatic spaces(input int n);
        for (int i = 0; i < n; i++) bit_time(1'b0, 1'b0, 1'b0);
    endtask

    // 192 data bits, then the next framing bit (the boundary strobe)
    task automatic send_frame(input int nsp, input int fsp);
        for (int i = 0; i < DATA_BITS; i++) begin
            if (i < nsp) bit_time(1'b0, 1'b0, 1'b0);
            else         mark(1'b0);
        end
        if (fsp != 0) bit_time(1'b0, 1'b0, 1'b1);
        else          mark(1'b1);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R12 carrier in reset", carrier_loss, 1'b0);
        chk("R12 ais in reset", ais_alarm, 1'b0);
        chk("R12 los in reset", loss_of_sync, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        mark(1'b0);
        chk("R12 carrier after reset", carrier_loss, 1'b0);
        chk("R12 los after reset", loss_of_sync, 1'b0);

        // carrier loss
        resync_auto_en = 1'b1;
        spaces(31);
        chk("R1 no loss at 31", carrier_loss, 1'b0);
        spaces(1);
        chk("R1 loss at 32", carrier_loss, 1'b1);
        chk("R9 los lags carrier", loss_of_sync, 1'b0);
        spaces(1);
        chk("R9 los from carrier", loss_of_sync, 1'b1);
        spaces(300);
        chk("R3 saturated run", carrier_loss, 1'b1);
        bit_time(1'b0, 1'b1, 1'b0);
        chk("R2 R4 neg-rail mark clears", carrier_loss, 1'b0);
        chk("R10 los one cycle after cause", loss_of_sync, 1'b1);
        bit_time(1'b1, 1'b0, 1'b0);
        chk("R10 los drops without busy", loss_of_sync, 1'b0);
        spaces(31);
        bit_time(1'b1, 1'b0, 1'b0);
        spaces(31);
        chk("R2 R4 pos-rail mark restarts run", carrier_loss, 1'b0);
        mark(1'b0);

        // loss of sync from out-of-frame
        resync_busy = 1'b1; oof_event = 1'b1;
        mark(1'b0);
        oof_event = 1'b0;
        chk("R9 los from oof", loss_of_sync, 1'b1);
        for (int i = 0; i < 10; i++) mark(1'b0);
        chk("R10 los held while busy", loss_of_sync, 1'b1);
        resync_busy = 1'b0;
        mark(1'b0);
        chk("R10 los drops after busy", loss_of_sync, 1'b0);
        resync_auto_en = 1'b0; oof_event = 1'b1; resync_busy = 1'b1;
        mark(1'b0);
        mark(1'b0);
        chk("R11 los off when disabled", loss_of_sync, 1'b0);
        oof_event = 1'b0; resync_busy = 1'b0;

        // AIS vectors, after one priming framing bit
        mark(1'b1);
        for (int v = 0; v < NVEC; v++) begin
            send_frame(VA[v], VF[v]);
            if (v == 0) chk("R8 no ais before two frames", ais_alarm, 1'b0);
            send_frame(VB[v], VF[v]);
            if (VF[v] != 0)
                chk("R6 framing spaces ignored", ais_alarm, VE[v] != 0);
            else if (VE[v] != 0)
                chk("R5 ais set", ais_alarm, 1'b1);
            else
                chk("R7 ais cleared", ais_alarm, 1'b0);
            chk("R5 carrier quiet in frames", carrier_loss, 1'b0);
        end
        // boundary-only update: spaces mid-frame do not move AIS
        for (int i = 0; i < 3; i++) bit_time(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 100; i++) mark(1'b0);
        chk("R5 no change mid-frame", ais_alarm, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule